// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a target-only two-wire serial slave holding a small bank of 8-bit configuration registers, which it presents to the chip as a flat parallel vector. It oversamples SCL and SDA with the system clock through a synchronizer and finds START and STOP conditions from the sampled levels. It reads and writes bits at the SCL edges and pulls SDA low through an open-drain enable. It never drives SCL and never begins a transfer.

A write transfer carries a starting register index, then a byte count, then that many data bytes. The data bytes land in consecutive registers and the index wraps inside the bank. To read, the master writes only the index, issues a repeated START with the read bit set, and then clocks out a count byte followed by register contents until it answers a byte with NACK. Clock stretching, packet error codes, alerts and bus timeouts are not part of the block.

Top module: `smb_regbank`

## Requirements
- R1: After reset every register reads 0x00 and SDA is not pulled.
- R2: The block answers only the 7-bit address 1101110 (address byte 0xDC for write, 0xDD for read, address MSB first with the R/W bit last, 0 = write) and ACKs that byte in both directions.
- R3: In a write transfer the block ACKs the index byte and a non-zero count byte N. It stores the following N data bytes, each ACKed, into the registers starting at the index and counting up.
- R4: A count byte of 0x00 is NACKed. No register changes, and every later byte of that transfer is NACKed.
- R5: Register positions are taken modulo NUM_REGS (a power of two). The upper bits of the index byte are dropped, and a run that passes the last register continues at register 0.
- R6: After a repeated START with the read bit, the block first sends a count byte equal to NUM_REGS (0x08 by default). It then sends registers from the last written index upward. It sends the next byte only while the master ACKs and releases SDA after a NACK.
- R7: When the address does not match, the block never pulls SDA, and no later byte changes a register or is ACKed until the next START.
- R8: Data bytes past the N announced by the count are NACKed and not stored.
- R9: A START or STOP in the middle of a byte abandons it. SDA is released, and the next START begins a new address byte that is handled normally.
- R10: The block changes its SDA pull only after a falling SCL, a START or a STOP, never while SCL stays high. Data bits go out MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level seen at the pad |
| sda_i | input | 1 | Serial data level seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Register bank, register k in bits [8k+7:8k] |

## Verification
Writes are tried with runs that stay inside the bank, runs that cross the top, and an index byte above the bank size. These cases separate correct modulo wrap from truncation or out-of-range writes. Count bytes of zero, and counts shorter than the data that follows, show whether the count alone gates storage and ACK. A foreign address followed by the real address byte without a START shows that the ignore state holds until the next START. Aborted bytes that end in STOP or in a repeated START show that the byte state machine restarts cleanly. Reads of one byte, of a few bytes and of the whole bank check the count byte, the wrap and the release after NACK. A per-clock comparison of the register vector against the bench model catches stray writes anywhere in these patterns.

// File: rtl/smb_pkg.sv
package smb_pkg;

    // Byte-level phases of the slave
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // bus free, waiting for START
        ST_ADDR = 3'd1,  // receiving address byte
        ST_OFFS = 3'd2,  // receiving start index
        ST_CNT  = 3'd3,  // receiving byte count
        ST_WDAT = 3'd4,  // receiving data bytes
        ST_TX   = 3'd5,  // sending count / register bytes
        ST_SKIP = 3'd6   // not addressed or finished: wait for START
    } st_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '1;
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '1;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/smb_cond.sv
module smb_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s &  scl_p_q;
    // SDA moves while SCL is held high on both samples
    assign bus_start = scl_s & scl_p_q &  sda_p_q & ~sda_s;
    assign bus_stop  = scl_s & scl_p_q & ~sda_p_q &  sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [7:0]            wdata_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_REGS*8-1:0] flat_o
);

    logic [7:0] mem_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            mem_q[r] <= 8'h00;
            else if (we_i && idx_i == IDX_W'(r))   mem_q[r] <= wdata_i;
        end
        assign flat_o[r*8 +: 8] = mem_q[r];
    end

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
    parameter int         NUM_REGS    = 8,
    parameter logic [6:0] DEV_ADDR    = 7'b1101110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    import smb_pkg::*;

    localparam int         IDX_W    = $clog2(NUM_REGS);
    localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);
    localparam logic [3:0] BIT_LAST = 4'(BYTE_W);       // all data bits seen
    localparam logic [3:0] BIT_ACK  = 4'(BYTE_W + 1);   // acknowledge slot

    typedef struct packed {
        st_e              st;
        logic [3:0]       bits;   // bits of current byte clocked so far
        logic [7:0]       sh;     // shift register
        logic [IDX_W-1:0] base;   // last index written by master
        logic [IDX_W-1:0] ptr;    // running register pointer
        logic [7:0]       rem;    // bytes still allowed / still to send
        logic             pull;   // SDA pull-low enable
        logic             mack;   // master acknowledged last sent byte
        logic             lead;   // count byte pending for transmission
    } ctl_t;

    ctl_t cur_q, cur_d;

    logic scl_s, sda_s;
    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic wr_en;
    logic [7:0] rd_byte;

    smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    smb_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (ev_rise),
        .scl_fall  (ev_fall),
        .bus_start (ev_start),
        .bus_stop  (ev_stop)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .idx_i   (cur_q.ptr),
        .wdata_i (cur_q.sh),
        .rdata_o (rd_byte),
        .flat_o  (regs_o)
    );

    logic rx_state;
    assign rx_state = (cur_q.st == ST_ADDR) || (cur_q.st == ST_OFFS) ||
                      (cur_q.st == ST_CNT)  || (cur_q.st == ST_WDAT);

    always_comb begin
        cur_d = cur_q;
        wr_en = 1'b0;

        if (ev_start) begin
            cur_d.st   = ST_ADDR;
            cur_d.bits = '0;
            cur_d.pull = 1'b0;
            cur_d.lead = 1'b0;
        end else if (ev_stop) begin
            cur_d.st   = ST_IDLE;
            cur_d.bits = '0;
            cur_d.pull = 1'b0;
            cur_d.lead = 1'b0;
        end else if (cur_q.st == ST_TX) begin
            if (ev_rise) begin
                if (cur_q.bits < BIT_LAST) begin
                    cur_d.bits = cur_q.bits + 4'd1;
                end else if (cur_q.bits == BIT_LAST) begin
                    cur_d.mack = ~sda_s;
                    cur_d.bits = BIT_ACK;
                end
            end else if (ev_fall) begin
                if (cur_q.bits >= 4'd1 && cur_q.bits < BIT_LAST) begin
                    cur_d.sh   = {cur_q.sh[6:0], 1'b0};
                    cur_d.pull = ~cur_q.sh[6];
                end else if (cur_q.bits == BIT_LAST) begin
                    cur_d.pull = 1'b0;                  // master's ack slot
                end else if (cur_q.bits == BIT_ACK) begin
                    cur_d.bits = '0;
                    if (cur_q.mack && cur_q.lead) begin
                        cur_d.lead = 1'b0;
                        cur_d.pull = ~cur_q.sh[7];
                    end else if (cur_q.mack && cur_q.rem != 8'd0) begin
                        cur_d.sh   = rd_byte;
                        cur_d.pull = ~rd_byte[7];
                        cur_d.ptr  = cur_q.ptr + IDX_W'(1);
                        cur_d.rem  = cur_q.rem - 8'd1;
                    end else begin
                        cur_d.st   = ST_SKIP;
                        cur_d.pull = 1'b0;
                    end
                end
            end
        end else if (rx_state) begin
            if (ev_rise && cur_q.bits < BIT_LAST) begin
                cur_d.sh   = {cur_q.sh[6:0], sda_s};
                cur_d.bits = cur_q.bits + 4'd1;
            end else if (ev_fall && cur_q.bits == BIT_LAST) begin
                cur_d.bits = BIT_ACK;
                unique case (cur_q.st)
                    ST_ADDR: begin
                        if (cur_q.sh[7:1] != DEV_ADDR) begin
                            cur_d.st = ST_SKIP;
                        end else if (cur_q.sh[0]) begin
                            cur_d.pull = 1'b1;
                            cur_d.st   = ST_TX;
                            cur_d.lead = 1'b1;
                            cur_d.mack = 1'b1;
                            cur_d.sh   = CNT_BYTE;
                            cur_d.ptr  = cur_q.base;
                            cur_d.rem  = CNT_BYTE;
                        end else begin
                            cur_d.pull = 1'b1;
                            cur_d.st   = ST_OFFS;
                        end
                    end
                    ST_OFFS: begin
                        cur_d.pull = 1'b1;
                        cur_d.base = cur_q.sh[IDX_W-1:0];
                        cur_d.ptr  = cur_q.sh[IDX_W-1:0];
                        cur_d.st   = ST_CNT;
                    end
                    ST_CNT: begin
                        if (cur_q.sh == 8'd0) begin
                            cur_d.st = ST_SKIP;
                        end else begin
                            cur_d.pull = 1'b1;
                            cur_d.rem  = cur_q.sh;
                            cur_d.st   = ST_WDAT;
                        end
                    end
                    default: begin                     // ST_WDAT
                        if (cur_q.rem != 8'd0) begin
                            wr_en      = 1'b1;
                            cur_d.pull = 1'b1;
                            cur_d.ptr  = cur_q.ptr + IDX_W'(1);
                            cur_d.rem  = cur_q.rem - 8'd1;
                        end
                    end
                endcase
            end else if (ev_fall && cur_q.bits == BIT_ACK) begin
                cur_d.pull = 1'b0;
                cur_d.bits = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign sda_pull_o = cur_q.pull;

endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk (
    input logic           clk,
    input logic           rst_n,
    input logic           sda_pull_o,
    input logic           ev_start,
    input logic           ev_stop,
    input logic           ev_fall,
    input logic           wr_en,
    input smb_pkg::st_e   st,
    input logic [7:0]     rem
);

    // R10
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> $past(ev_fall || ev_start || ev_stop));

    // R7
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == smb_pkg::ST_SKIP) |-> !sda_pull_o);

    // R8
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st == smb_pkg::ST_WDAT && rem != 8'd0));

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (!sda_pull_o && st == smb_pkg::ST_ADDR));

endmodule

bind smb_regbank smb_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_fall    (ev_fall),
    .wr_en      (wr_en),
    .st         (cur_q.st),
    .rem        (cur_q.rem)
);

// File: tb/tb_smb_regbank.sv
module tb_smb_regbank;

    localparam int         NREG = 8;
    localparam int         HALF = 8;
    localparam logic [6:0] ADDR = 7'b1101110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1;
    logic m_pull = 1'b0;
    logic pull;
    logic sda_w;
    logic [NREG*8-1:0] regs;

    assign sda_w = ~(m_pull | pull);

    always #5 clk = ~clk;

    smb_regbank dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_r),
        .sda_i      (sda_w),
        .sda_pull_o (pull),
        .regs_o     (regs)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [NREG];
    int  base_m = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference register image compared every clock outside write bytes (R3)
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int i = 0; i < NREG; i++)
                chk(regs[i*8 +: 8] == mdl[i], "R3", "register image",
                    int'(regs[i*8 +: 8]), int'(mdl[i]));
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_pull = 1'b0; wt(HALF);
        scl_r  = 1'b1; wt(HALF);
        m_pull = 1'b1; wt(HALF);
        scl_r  = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        scl_r  = 1'b0;
        m_pull = 1'b1; wt(HALF);
        scl_r  = 1'b1; wt(HALF);
        m_pull = 1'b0; wt(2 * HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            m_pull = ~b[i]; wt(HALF);
            scl_r  = 1'b1;  wt(HALF);
            scl_r  = 1'b0;  wt(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit steady);
        bit s1;
        send_bits(b, 8);
        m_pull = 1'b0; wt(HALF);
        scl_r  = 1'b1; wt(3);
        s1 = sda_w;
        wt(HALF - 3);
        steady = (s1 == sda_w);
        ack = ~s1;
        scl_r = 1'b0; wt(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(HALF);
            scl_r = 1'b1; wt(HALF / 2);
            b[i] = sda_w; wt(HALF / 2);
            scl_r = 1'b0; wt(2);
        end
        m_pull = mack; wt(HALF);
        scl_r  = 1'b1; wt(HALF);
        scl_r  = 1'b0; wt(2);
        m_pull = 1'b0;
    endtask

    task automatic snd(input logic [7:0] b, input bit exp_ack, input string req,
                       input int widx, input string what);
        bit ack, steady;
        cmp_en = 1'b0;
        send_byte(b, ack, steady);
        chk(ack == exp_ack, req, what, int'(ack), int'(exp_ack));
        chk(steady, "R10", "SDA steady while SCL high", int'(steady), 1);
        if (widx >= 0 && exp_ack) mdl[widx] = b;
        cmp_en = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] off, input logic [7:0] n,
                          input logic [7:0] d[$], input string dtag);
        bit match = (a == ADDR);
        bit live;
        bus_start();
        snd({a, 1'b0}, match, match ? "R2" : "R7", -1, "address");
        if (match) base_m = int'(off) % NREG;
        snd(off, match, match ? "R3" : "R7", -1, "index");
        snd(n, match && n != 0, match ? "R4" : "R7", -1, "count");
        live = match && n != 0;
        foreach (d[i]) begin
            bit take = live && (i < int'(n));
            snd(d[i], take, !match ? "R7" : (n == 0 ? "R4" : (take ? dtag : "R8")),
                take ? (base_m + i) % NREG : -1, "data");
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] off, input int k, input string tag);
        logic [7:0] b;
        bus_start();
        snd({ADDR, 1'b0}, 1'b1, "R2", -1, "address");
        snd(off, 1'b1, "R6", -1, "index");
        base_m = int'(off) % NREG;
        bus_start();
        snd({ADDR, 1'b1}, 1'b1, "R2", -1, "read address");
        recv_byte(1'b1, b);
        chk(b == 8'(NREG), "R6", "count byte", int'(b), NREG);
        for (int i = 0; i < k; i++) begin
            recv_byte(i != k - 1, b);
            chk(b == mdl[(base_m + i) % NREG], tag, "read data",
                int'(b), int'(mdl[(base_m + i) % NREG]));
        end
        wt(2);
        chk(pull == 1'b0, "R6", "released after NACK", int'(pull), 0);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        wt(4);
        rst_n = 1'b1;
        wt(4);
        // R1: reset state
        chk(regs == '0, "R1", "registers after reset", int'(regs[31:0]), 0);
        chk(pull == 1'b0, "R1", "SDA pull after reset", int'(pull), 0);
        cmp_en = 1'b1;

        // R3: plain write inside the bank, then read back
        wr_txn(ADDR, 8'd2, 8'd3, '{8'h11, 8'h22, 8'h33}, "R3");
        rd_txn(8'd2, 3, "R6");
        // R5: run crossing the top of the bank
        wr_txn(ADDR, 8'd6, 8'd4, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R5");
        rd_txn(8'd6, 4, "R5");
        // R5: index byte above bank size
        wr_txn(ADDR, 8'h0D, 8'd2, '{8'h5A, 8'hA5}, "R5");
        rd_txn(8'd0, NREG, "R6");
        // R4: zero count
        wr_txn(ADDR, 8'd1, 8'd0, '{8'h55, 8'h66}, "R4");
        // R8: more data than announced
        wr_txn(ADDR, 8'd0, 8'd2, '{8'h01, 8'h02, 8'h03, 8'h04}, "R3");
        // R7: foreign address, then the real address byte without START
        wr_txn(7'b1011101, 8'd3, 8'd1, '{8'h77, {ADDR, 1'b0}, 8'h00}, "R7");
        // R9: byte cut short by STOP
        bus_start();
        send_bits({ADDR, 1'b0}, 4);
        bus_stop();
        chk(pull == 1'b0, "R9", "released after STOP abort", int'(pull), 0);
        wr_txn(ADDR, 8'd4, 8'd1, '{8'h9C}, "R9");
        // R9: byte cut short by repeated START
        bus_start();
        send_bits(8'hFF, 3);
        wr_txn(ADDR, 8'd5, 8'd1, '{8'h3E}, "R9");
        // R6: single data byte read
        rd_txn(8'd5, 1, "R6");
        rd_txn(8'd0, NREG, "R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            cmp_en = 1'b0;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule